// File: doc/BRIEF.md
# BCD Calendar Time Counter

This core keeps wall-clock time and date in packed BCD: seconds, minutes, hours, day of month, weekday, month and a two-digit year. An internal prescaler counts pulses on a sub-second enable input. Every `PRESCALE` pulses it advances the seconds field. Carries ripple up through the calendar. Month lengths are honoured, and February gets a 29th day in every year divisible by four.

A host reaches the core through a single-cycle register port. Writes land on the clock edge, and reads are combinational from the addressed register.

The control register holds three things:
- a stop bit that freezes counting;
- a 12/24-hour selector;
- a software-reset command code.

An oscillator-stopped flag in the top bit of the seconds register records that the stored time cannot be trusted. It stays set until the host rewrites the seconds.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read as follows:
  - seconds 0x80 (flag set, count 00);
  - minutes 0x00, hours 0x00, weekday 0x00;
  - day 0x01, month 0x01, year 0x00;
  - control 0x00.
- R2: The register addresses are:
  - 0x0 control;
  - 0x2 seconds, 0x3 minutes, 0x4 hours, 0x5 day, 0x6 weekday, 0x7 month, 0x8 year.

  Writes keep only the legal field bits:
  - minutes use bits 6:0;
  - hours and day use bits 5:0;
  - weekday uses bits 2:0;
  - month uses bits 4:0;
  - year uses all 8 bits.

  Unkept bits read 0, and any unmapped address reads 0x00.
- R3: Bit 7 of the seconds register is the oscillator-stopped flag. Reset sets it. Only a seconds write changes it, and that write loads the flag from data bit 7.
- R4: While control bit 5 (stop) is 1, no time field changes and the prescaler holds its count.
- R5: The seconds field advances once per `PRESCALE` sub-tick pulses. Seconds and minutes wrap from 59 to 00, and each wrap carries into the next field.
- R6: In 24-hour mode (control bit 2 = 0), hours wrap from 23 to 00 and the wrap advances the day.
- R7: In 12-hour mode (control bit 2 = 1), hours bit 5 is PM and bits 4:0 hold 01..12 in BCD. The hour sequence is:
  - 11 AM goes to 12 PM;
  - 12 PM goes to 01 PM;
  - 11 PM goes to 12 AM and advances the day;
  - 12 AM goes to 01 AM.
- R8: The day wraps to 01 after the last day of the month. April, June, September and November have 30 days; the other months have 31, except February. February has 29 days when the year is divisible by 4 and 28 otherwise. Each day advance also steps the weekday, which wraps from 6 to 0. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R9: Writing 0x58 to the control register clears stop and 12-hour mode and sets the oscillator-stopped flag. The control register then reads 0x00, not 0x58, and the time fields are unchanged.
- R10: A write to any time register clears the prescaler and cancels a second advance in that cycle, so the next advance comes a full `PRESCALE` pulses later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | Sub-second enable pulse, one clock wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |

## Verification
The range assertions on seconds, minutes and weekday rely on the host writing only legal BCD values, because the counter does not repair an illegal value. The stop assertion assumes host writes are the only other cause of change. The bench therefore loads only in-range BCD times. The mask test uses data whose kept bits still form a legal value, so every write stays inside those assumptions.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_SEC  = 4'h2;
    localparam logic [3:0] A_MIN  = 4'h3;
    localparam logic [3:0] A_HOUR = 4'h4;
    localparam logic [3:0] A_DAY  = 4'h5;
    localparam logic [3:0] A_WDAY = 4'h6;
    localparam logic [3:0] A_MON  = 4'h7;
    localparam logic [3:0] A_YEAR = 4'h8;
    localparam logic [7:0] SRST_CODE = 8'h58;
    localparam int STOP_BIT = 5;
    localparam int H12_BIT  = 2;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        rtc_time_t t;
        logic      osf;
        logic      stop;
        logic      mode12;
    } rtc_state_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [5:0] month_days(input logic [4:0] mon, input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
        case (mon)
            5'h02:                      return (ybin[1:0] == 2'b00) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick,
    input  logic hold,
    input  logic clr,
    output logic sec_tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        sec_tick = sub_tick && !hold && (cnt_q == LAST);
        cnt_d    = cnt_q;
        if (clr)                    cnt_d = '0;
        else if (sub_tick && !hold) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      mode12,
    output rtc_time_t nxt
);
    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] t8;
    logic [4:0] h5;
    logic       pm;

    always_comb begin
        nxt    = cur;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        h5     = cur.hour[4:0];
        pm     = cur.hour[5];
        t8     = 8'h00;

        if (cur.sec == 7'h59) begin
            nxt.sec = 7'h00;
            c_min   = 1'b1;
        end else begin
            t8      = bcd_inc({1'b0, cur.sec});
            nxt.sec = t8[6:0];
        end

        if (c_min) begin
            if (cur.min == 7'h59) begin
                nxt.min = 7'h00;
                c_hour  = 1'b1;
            end else begin
                t8      = bcd_inc({1'b0, cur.min});
                nxt.min = t8[6:0];
            end
        end

        if (c_hour) begin
            if (mode12) begin
                if (h5 == 5'h11) begin
                    nxt.hour = {~pm, 5'h12};
                    c_day    = pm;
                end else if (h5 == 5'h12) begin
                    nxt.hour = {pm, 5'h01};
                end else begin
                    t8       = bcd_inc({3'b000, h5});
                    nxt.hour = {pm, t8[4:0]};
                end
            end else if (cur.hour == 6'h23) begin
                nxt.hour = 6'h00;
                c_day    = 1'b1;
            end else begin
                t8       = bcd_inc({2'b00, cur.hour});
                nxt.hour = t8[5:0];
            end
        end

        if (c_day) begin
            nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
            if (cur.day == month_days(cur.mon, cur.year)) begin
                nxt.day = 6'h01;
                c_mon   = 1'b1;
            end else begin
                t8      = bcd_inc({2'b00, cur.day});
                nxt.day = t8[5:0];
            end
        end

        if (c_mon) begin
            if (cur.mon == 5'h12) begin
                nxt.mon = 5'h01;
                c_year  = 1'b1;
            end else begin
                t8      = bcd_inc({3'b000, cur.mon});
                nxt.mon = t8[4:0];
            end
        end

        if (c_year) nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
    end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    localparam rtc_state_t RST_STATE = '{
        t: '{sec: 7'h00, min: 7'h00, hour: 6'h00, day: 6'h01,
             wday: 3'd0, mon: 5'h01, year: 8'h00},
        osf: 1'b1, stop: 1'b0, mode12: 1'b0};

    rtc_state_t q, d;
    rtc_time_t  t_next;
    logic       time_wr, sec_tick;

    assign time_wr = wr_en && (addr >= A_SEC) && (addr <= A_YEAR);

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_tick (sub_tick),
        .hold     (q.stop),
        .clr      (time_wr),
        .sec_tick (sec_tick)
    );

    rtc_calendar_step u_step (
        .cur    (q.t),
        .mode12 (q.mode12),
        .nxt    (t_next)
    );

    always_comb begin
        d = q;
        if (sec_tick && !time_wr) d.t = t_next;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    if (wr_data == SRST_CODE) begin
                        d.stop   = 1'b0;
                        d.mode12 = 1'b0;
                        d.osf    = 1'b1;
                    end else begin
                        d.stop   = wr_data[STOP_BIT];
                        d.mode12 = wr_data[H12_BIT];
                    end
                end
                A_SEC: begin
                    d.osf   = wr_data[7];
                    d.t.sec = wr_data[6:0];
                end
                A_MIN:   d.t.min  = wr_data[6:0];
                A_HOUR:  d.t.hour = wr_data[5:0];
                A_DAY:   d.t.day  = wr_data[5:0];
                A_WDAY:  d.t.wday = wr_data[2:0];
                A_MON:   d.t.mon  = wr_data[4:0];
                A_YEAR:  d.t.year = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_STATE;
        else        q <= d;
    end

    always_comb begin
        rd_data = 8'h00;
        case (addr)
            A_CTRL: begin
                rd_data[STOP_BIT] = q.stop;
                rd_data[H12_BIT]  = q.mode12;
            end
            A_SEC:   rd_data = {q.osf, q.t.sec};
            A_MIN:   rd_data = {1'b0, q.t.min};
            A_HOUR:  rd_data = {2'b00, q.t.hour};
            A_DAY:   rd_data = {2'b00, q.t.day};
            A_WDAY:  rd_data = {5'b00000, q.t.wday};
            A_MON:   rd_data = {3'b000, q.t.mon};
            A_YEAR:  rd_data = q.t.year;
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] addr,
    input logic [7:0] wr_data,
    input rtc_state_t st
);
    // R4: frozen time while stopped and untouched by the host
    p_stop_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st.stop && !wr_en) |=> $stable(st.t));

    // R5: seconds and minutes stay legal BCD 00..59
    p_sec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st.t.sec[3:0] <= 4'd9) && (st.t.sec[6:4] <= 3'd5));
    p_min_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st.t.min[3:0] <= 4'd9) && (st.t.min[6:4] <= 3'd5));

    // R8: weekday never exceeds 6
    p_wday_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st.t.wday <= 3'd6);

    // R9: reset command clears control and raises the flag
    p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && wr_data == SRST_CODE) |=> (st.osf && !st.stop && !st.mode12));

    // R3: flag only drops through a seconds write
    p_osf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st.osf && !(wr_en && addr == A_SEC)) |=> st.osf);
endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .st      (q)
);

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
    localparam int PS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    bcd_rtc_core #(.PRESCALE(PS)) u_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0h: got %02h expected %02h", req, a, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sub_tick = 1'b1;
            @(negedge clk); sub_tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] s, m, h, dy, w, mo, y);
        wr(4'h2, s); wr(4'h3, m); wr(4'h4, h); wr(4'h5, dy);
        wr(4'h6, w); wr(4'h7, mo); wr(4'h8, y);
    endtask

    task automatic t_reset();
        chk("R1", 4'h2, 8'h80); chk("R1", 4'h3, 8'h00); chk("R1", 4'h4, 8'h00);
        chk("R1", 4'h5, 8'h01); chk("R1", 4'h6, 8'h00); chk("R1", 4'h7, 8'h01);
        chk("R1", 4'h8, 8'h00); chk("R1", 4'h0, 8'h00);
    endtask

    task automatic t_masks();
        wr(4'h3, 8'hD9); chk("R2", 4'h3, 8'h59);
        wr(4'h4, 8'hE3); chk("R2", 4'h4, 8'h23);
        wr(4'h5, 8'hD5); chk("R2", 4'h5, 8'h15);
        wr(4'h6, 8'hFE); chk("R2", 4'h6, 8'h06);
        wr(4'h7, 8'hF2); chk("R2", 4'h7, 8'h12);
        wr(4'h8, 8'h99); chk("R2", 4'h8, 8'h99);
        wr(4'h0, 8'hFF); chk("R2", 4'h0, 8'h24);
        wr(4'h0, 8'h00);
        chk("R2", 4'h1, 8'h00); chk("R2", 4'hA, 8'h00);
    endtask

    task automatic t_osf();
        chk("R3", 4'h2, 8'h80);
        wr(4'h2, 8'h05); chk("R3", 4'h2, 8'h05);
        wr(4'h2, 8'h87); chk("R3", 4'h2, 8'h87);
        wr(4'h2, 8'h07); chk("R3", 4'h2, 8'h07);
    endtask

    task automatic t_count();
        set_time(8'h58, 8'h59, 8'h10, 8'h10, 8'h02, 8'h05, 8'h20);
        ticks(PS - 1); chk("R5", 4'h2, 8'h58);
        ticks(1);      chk("R5", 4'h2, 8'h59);
        ticks(PS);     chk("R5", 4'h2, 8'h00);
        chk("R5", 4'h3, 8'h00); chk("R5", 4'h4, 8'h11);
    endtask

    task automatic t_stop();
        set_time(8'h30, 8'h00, 8'h05, 8'h03, 8'h01, 8'h06, 8'h21);
        wr(4'h0, 8'h20);
        ticks(2 * PS); chk("R4", 4'h2, 8'h30);
        wr(4'h0, 8'h00);
        ticks(PS);     chk("R4", 4'h2, 8'h31);
    endtask

    task automatic t_prescale_clear();
        set_time(8'h10, 8'h00, 8'h05, 8'h03, 8'h01, 8'h06, 8'h21);
        ticks(PS - 1);
        wr(4'h3, 8'h01);
        ticks(PS - 1); chk("R10", 4'h2, 8'h10);
        ticks(1);      chk("R10", 4'h2, 8'h11);
    endtask

    task automatic t_hours24();
        set_time(8'h59, 8'h59, 8'h23, 8'h14, 8'h03, 8'h06, 8'h21);
        ticks(PS);
        chk("R6", 4'h4, 8'h00); chk("R6", 4'h5, 8'h15); chk("R6", 4'h6, 8'h04);
    endtask

    task automatic t_hours12();
        wr(4'h0, 8'h04);
        set_time(8'h59, 8'h59, 8'h11, 8'h10, 8'h01, 8'h06, 8'h21);
        ticks(PS); chk("R7", 4'h4, 8'h32); chk("R7", 4'h5, 8'h10);
        set_time(8'h59, 8'h59, 8'h32, 8'h10, 8'h01, 8'h06, 8'h21);
        ticks(PS); chk("R7", 4'h4, 8'h21);
        set_time(8'h59, 8'h59, 8'h31, 8'h10, 8'h01, 8'h06, 8'h21);
        ticks(PS); chk("R7", 4'h4, 8'h12); chk("R7", 4'h5, 8'h11);
        set_time(8'h59, 8'h59, 8'h12, 8'h10, 8'h01, 8'h06, 8'h21);
        ticks(PS); chk("R7", 4'h4, 8'h01);
        wr(4'h0, 8'h00);
    endtask

    task automatic t_calendar();
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h06, 8'h02, 8'h24);
        ticks(PS); chk("R8", 4'h5, 8'h29); chk("R8", 4'h6, 8'h00); chk("R8", 4'h7, 8'h02);
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h23);
        ticks(PS); chk("R8", 4'h5, 8'h01); chk("R8", 4'h7, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h02, 8'h04, 8'h23);
        ticks(PS); chk("R8", 4'h5, 8'h01); chk("R8", 4'h7, 8'h05);
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h02, 8'h01, 8'h23);
        ticks(PS); chk("R8", 4'h5, 8'h31);
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h05, 8'h12, 8'h99);
        ticks(PS); chk("R8", 4'h5, 8'h01); chk("R8", 4'h7, 8'h01);
        chk("R8", 4'h8, 8'h00); chk("R8", 4'h6, 8'h06);
    endtask

    task automatic t_soft_reset();
        set_time(8'h12, 8'h34, 8'h05, 8'h07, 8'h03, 8'h08, 8'h42);
        wr(4'h0, 8'h24); chk("R9", 4'h0, 8'h24);
        wr(4'h0, 8'h58); chk("R9", 4'h0, 8'h00);
        chk("R9", 4'h2, 8'h92); chk("R9", 4'h3, 8'h34); chk("R9", 4'h8, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_osf();
        t_count();
        t_stop();
        t_prescale_clear();
        t_hours24();
        t_hours12();
        t_calendar();
        t_soft_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule